// File: doc/BRIEF.md
# Sectored Pseudo-LRU Replacement Selector

This block picks the way to evict from one set of a 16-way set-associative cache. The sixteen ways are paired into eight sectors (sector `s` holds ways `2s` and `2s+1`). Recency is kept per sector, not per way. Each set stores a full age ordering of its eight sectors plus one bit per sector naming which way of the pair was touched last. That is 32 bits per set, half of what exact 16-way LRU needs.

The surrounding cache presents a set index with every operation. An access strobe reports a hit or a fill to a given way, and that sector becomes the newest of its set. A victim request, together with the per-way valid vector of the set, loads the chosen way into a registered output one cycle later. Invalid ways are always used first. Otherwise the pick comes from the oldest sector, taking the way of that pair that was not touched last. A victim request never changes the recency state. Only the access that performs the fill does.

Top module: `sectored_plru`

## Requirements
- R1: A synchronous reset sets `victim_way` to 0 and sets every set's ordering to sector 0 oldest through sector 7 newest, with all last-touched bits 0. The first all-valid victim of any set after reset is therefore way 1.
- R2: When `victim_req` is high and any bit of `way_valid` is 0, the victim is the lowest-numbered way whose valid bit is 0.
- R3: When all sixteen ways are valid, the victim lies in the set's least recently touched sector.
- R4: Sector `s` holds ways `2s` and `2s+1`. Within the victim sector, the chosen way is the one not touched last: way `2s+1` when way `2s` was touched last or the sector has not been touched since reset, and way `2s` otherwise.
- R5: An access (`access_valid` high) to way `w` makes sector `w/2` the newest of the set, leaves the relative order of the other sectors unchanged, and records `w[0]` as that sector's last-touched way.
- R6: A victim request alone leaves the recency state unchanged. Repeated requests on the same set and valid vector return the same way.
- R7: `victim_way` updates at the clock edge where `victim_req` is high and holds its value in all other cycles.
- R8: Accesses to one set have no effect on the victim chosen in any other set.
- R9: When an access and a victim request occur in the same cycle, the victim comes from the state before that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| set_idx | input | SET_W | Set addressed by this cycle's access and request |
| access_valid | input | 1 | A hit or fill to `access_way` occurs in this cycle |
| access_way | input | 4 | Way that hit or was filled |
| victim_req | input | 1 | Request a victim for `set_idx` |
| way_valid | input | 16 | Valid bit of each way of the addressed set |
| victim_way | output | 4 | Registered victim way, updated one cycle after `victim_req` |

## Verification
A corrupted sector ordering shows up at the next all-valid victim request on that set, one cycle after the request. The wrong sector appears in `victim_way[3:1]`, or a duplicated sector leaves some sector never chosen. A wrong last-touched bit flips `victim_way[0]` on the same request. A state update leaking from a request or into another set changes the victim on the next request to the affected set. Because the failure only becomes visible when that set is next asked for a victim, the stimulus interleaves accesses and requests across sets, and it issues same-cycle access/request pairs.

// File: rtl/plru_pkg.sv
package plru_pkg;
    parameter int unsigned WAYS      = 16;
    parameter int unsigned PAIR      = 2;
    localparam int unsigned SECTORS  = WAYS / PAIR;
    localparam int unsigned SECT_W   = $clog2(SECTORS);
    localparam int unsigned WAY_W    = $clog2(WAYS);

    typedef logic [SECT_W-1:0] sect_t;
    typedef logic [WAY_W-1:0]  way_t;

    // order[0] is the oldest sector, order[SECTORS-1] the newest
    typedef struct packed {
        sect_t [SECTORS-1:0]  order;
        logic  [SECTORS-1:0]  last_hi;
    } set_state_t;

    function automatic set_state_t init_state();
        set_state_t s;
        for (int p = 0; p < SECTORS; p++) begin
            s.order[p] = sect_t'(p);
        end
        s.last_hi = '0;
        return s;
    endfunction
endpackage

// File: rtl/plru_touch.sv
module plru_touch
    import plru_pkg::*;
(
    input  set_state_t cur,
    input  way_t       way,
    output set_state_t nxt
);
    sect_t sec;
    logic  shifting;

    always_comb begin
        sec      = way[WAY_W-1:1];
        nxt      = cur;
        shifting = 1'b0;
        for (int p = 0; p < SECTORS - 1; p++) begin
            if (cur.order[p] == sec) begin
                shifting = 1'b1;
            end
            if (shifting) begin
                nxt.order[p] = cur.order[p+1];
            end
        end
        nxt.order[SECTORS-1] = sec;
        nxt.last_hi[sec]     = way[0];
    end
endmodule

// File: rtl/plru_pick.sv
module plru_pick
    import plru_pkg::*;
(
    input  set_state_t       cur,
    input  logic [WAYS-1:0]  valid,
    output way_t             victim
);
    sect_t oldest;

    always_comb begin
        oldest = cur.order[0];
        victim = {oldest, ~cur.last_hi[oldest]};
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!valid[w]) begin
                victim = way_t'(w);
            end
        end
    end
endmodule

// File: rtl/sectored_plru.sv
module sectored_plru
    import plru_pkg::*;
#(
    parameter int unsigned NUM_SETS = 16,
    localparam int unsigned SET_W   = $clog2(NUM_SETS)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [SET_W-1:0]   set_idx,
    input  logic               access_valid,
    input  logic [WAY_W-1:0]   access_way,
    input  logic               victim_req,
    input  logic [WAYS-1:0]    way_valid,
    output logic [WAY_W-1:0]   victim_way
);
    typedef struct packed {
        set_state_t [NUM_SETS-1:0] sets;
        way_t                      vic;
    } regs_t;

    regs_t      r_d, r_q;
    set_state_t cur_set;
    set_state_t touched_set;
    way_t       picked_way;

    assign cur_set = r_q.sets[set_idx];

    plru_touch u_touch (
        .cur (cur_set),
        .way (access_way),
        .nxt (touched_set)
    );

    plru_pick u_pick (
        .cur    (cur_set),
        .valid  (way_valid),
        .victim (picked_way)
    );

    always_comb begin
        r_d = r_q;
        if (victim_req) begin
            r_d.vic = picked_way;
        end
        if (access_valid) begin
            r_d.sets[set_idx] = touched_set;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < NUM_SETS; s++) begin
                r_q.sets[s] <= init_state();
            end
            r_q.vic <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign victim_way = r_q.vic;
endmodule

// File: rtl/plru_checker.sv
module plru_checker
    import plru_pkg::*;
#(
    parameter int unsigned NUM_SETS = 16,
    localparam int unsigned SET_W   = $clog2(NUM_SETS)
) (
    input logic                       clk,
    input logic                       rst,
    input logic [SET_W-1:0]           set_idx,
    input logic                       access_valid,
    input logic [WAY_W-1:0]           access_way,
    input logic                       victim_req,
    input logic [WAYS-1:0]            way_valid,
    input logic [WAY_W-1:0]           victim_way,
    input set_state_t [NUM_SETS-1:0]  sets
);
    logic            rst_q = 1'b0;
    logic [WAYS-1:0] valid_q = '1;

    always @(posedge clk) begin
        if (rst_q) begin
            p_reset_state_r1: assert (victim_way == '0 && sets[0] == init_state());
        end
        for (int s = 0; s < NUM_SETS; s++) begin
            logic [SECTORS-1:0] seen;
            seen = '0;
            for (int p = 0; p < SECTORS; p++) begin
                seen[sets[s].order[p]] = 1'b1;
            end
            if (!rst_q && !rst) begin
                p_order_perm_r5: assert (&seen);
            end
        end
        rst_q   <= rst;
        valid_q <= way_valid;
    end

    p_invalid_first_r2: assert property (@(posedge clk) disable iff (rst)
        victim_req && !(&way_valid) |=> !valid_q[victim_way]);

    p_oldest_sector_r3: assert property (@(posedge clk) disable iff (rst)
        victim_req && (&way_valid) |=> victim_way[WAY_W-1:1] == $past(sets[set_idx].order[0]));

    p_touch_newest_r5: assert property (@(posedge clk) disable iff (rst)
        access_valid |=> sets[$past(set_idx)].order[SECTORS-1] == $past(access_way[WAY_W-1:1]));

    p_request_keeps_state_r6: assert property (@(posedge clk) disable iff (rst)
        victim_req && !access_valid |=> $stable(sets));

    p_hold_output_r7: assert property (@(posedge clk) disable iff (rst)
        !victim_req |=> $stable(victim_way));
endmodule

bind sectored_plru plru_checker #(.NUM_SETS(NUM_SETS)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .set_idx      (set_idx),
    .access_valid (access_valid),
    .access_way   (access_way),
    .victim_req   (victim_req),
    .way_valid    (way_valid),
    .victim_way   (victim_way),
    .sets         (r_q.sets)
);

// File: tb/sectored_plru_tb.sv
module sectored_plru_tb;
    localparam int NSETS = 16;
    localparam int NVEC  = 20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  set_idx = '0;
    logic        access_valid = 1'b0;
    logic [3:0]  access_way = '0;
    logic        victim_req = 1'b0;
    logic [15:0] way_valid = '1;
    logic [3:0]  victim_way;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // independent model: age stamps per sector, last touched way bit
    int ts [NSETS][8];
    bit lb [NSETS][8];
    int tick;

    always #4 clk = ~clk;

    sectored_plru #(.NUM_SETS(NSETS)) u_dut (
        .clk          (clk),
        .rst          (rst),
        .set_idx      (set_idx),
        .access_valid (access_valid),
        .access_way   (access_way),
        .victim_req   (victim_req),
        .way_valid    (way_valid),
        .victim_way   (victim_way)
    );

    // {set[3:0], acc, way[3:0], vic, valid[15:0]}
    localparam logic [25:0] VEC [NVEC] = '{
        {4'd0, 1'b0, 4'd0,  1'b1, 16'hFFFF},
        {4'd0, 1'b1, 4'd3,  1'b0, 16'hFFFF},
        {4'd0, 1'b0, 4'd0,  1'b1, 16'hFFFF},
        {4'd0, 1'b1, 4'd0,  1'b0, 16'hFFFF},
        {4'd0, 1'b0, 4'd0,  1'b1, 16'hFFFF},
        {4'd1, 1'b1, 4'd15, 1'b1, 16'hFFFF},
        {4'd1, 1'b0, 4'd0,  1'b1, 16'hFFFF},
        {4'd1, 1'b1, 4'd1,  1'b0, 16'hFFFF},
        {4'd1, 1'b0, 4'd0,  1'b1, 16'hFFFF},
        {4'd2, 1'b0, 4'd0,  1'b1, 16'hFFDF},
        {4'd2, 1'b0, 4'd0,  1'b1, 16'h7FFF},
        {4'd2, 1'b0, 4'd0,  1'b1, 16'h0000},
        {4'd3, 1'b1, 4'd6,  1'b0, 16'hFFFF},
        {4'd3, 1'b1, 4'd1,  1'b0, 16'hFFFF},
        {4'd3, 1'b1, 4'd2,  1'b1, 16'hFFFF},
        {4'd3, 1'b0, 4'd0,  1'b1, 16'hFFFF},
        {4'd3, 1'b1, 4'd9,  1'b1, 16'hFFFF},
        {4'd3, 1'b0, 4'd0,  1'b1, 16'hFFFF},
        {4'd3, 1'b0, 4'd0,  1'b1, 16'hFDFF},
        {4'd0, 1'b1, 4'd2,  1'b1, 16'hFFFF}
    };

    function automatic int model_victim(int s, logic [15:0] v);
        int best;
        for (int w = 0; w < 16; w++) begin
            if (!v[w]) return w;
        end
        best = 0;
        for (int k = 1; k < 8; k++) begin
            if (ts[s][k] < ts[s][best]) best = k;
        end
        return 2 * best + (lb[s][best] ? 0 : 1);
    endfunction

    task automatic model_reset();
        for (int s = 0; s < NSETS; s++) begin
            for (int k = 0; k < 8; k++) begin
                ts[s][k] = k;
                lb[s][k] = 1'b0;
            end
        end
        tick = 8;
    endtask

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: victim_way=%0d expected %0d", req, act, exp);
        end
    endtask

    // one operation; returns the expected victim (or -1 when no request)
    task automatic step(input int s, input bit acc, input int way, input bit vic,
                        input logic [15:0] v, output int exp);
        @(negedge clk);
        set_idx      = 4'(s);
        access_valid = acc;
        access_way   = 4'(way);
        victim_req   = vic;
        way_valid    = v;
        exp = vic ? model_victim(s, v) : -1;
        @(posedge clk);
        if (acc) begin
            ts[s][way/2] = tick;
            lb[s][way/2] = way[0];
            tick++;
        end
        #2;
        access_valid = 1'b0;
        victim_req   = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int e;
        int held;
        model_reset();
        repeat (3) @(posedge clk);
        #2;
        rst = 1'b0;
        check("R1 reset output", int'(victim_way), 0);

        step(5, 0, 0, 1, 16'hFFFF, e);
        check("R1 first victim after reset", int'(victim_way), 1);

        for (int i = 0; i < NVEC; i++) begin
            logic [25:0] r;
            r = VEC[i];
            step(int'(r[25:22]), r[21], int'(r[20:17]), r[16], r[15:0], e);
            if (e >= 0) begin
                check("R2 R3 R4 R5 R9 table vector", int'(victim_way), e);
            end
        end

        // R7: idle cycles with changing inputs leave the output alone
        held = int'(victim_way);
        step(0, 0, 0, 0, 16'h0000, e);
        step(3, 0, 0, 0, 16'h00F0, e);
        check("R7 output holds without request", int'(victim_way), held);

        // R6: repeated requests return the same way
        step(4, 1, 8, 0, 16'hFFFF, e);
        step(4, 0, 0, 1, 16'hFFFF, e);
        check("R6 first request", int'(victim_way), e);
        step(4, 0, 0, 1, 16'hFFFF, e);
        check("R6 repeated request unchanged", int'(victim_way), e);

        // R8: heavy use of set 6 leaves set 7 at its reset choice
        for (int w = 0; w < 16; w++) begin
            step(6, 1, w, 0, 16'hFFFF, e);
        end
        step(7, 0, 0, 1, 16'hFFFF, e);
        check("R8 other set untouched", int'(victim_way), 1);
        step(6, 0, 0, 1, 16'hFFFF, e);
        check("R8 R4 touched set follows its own history", int'(victim_way), e);

        // R9: request with access in same cycle uses old state (way 1)
        step(8, 1, 0, 1, 16'hFFFF, e);
        check("R9 same-cycle access and request", int'(victim_way), 1);

        // R2: single invalid way at the top end
        step(9, 0, 0, 1, 16'h7FFF, e);
        check("R2 highest way invalid", int'(victim_way), 15);

        // R1: a second reset restores the initial ordering
        @(negedge clk);
        rst = 1'b1;
        model_reset();
        @(posedge clk);
        #2;
        rst = 1'b0;
        check("R1 output after second reset", int'(victim_way), 0);
        step(0, 0, 0, 1, 16'hFFFF, e);
        check("R1 set 0 ordering after second reset", int'(victim_way), 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule